// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a parameterised register, eight bits wide by default, that updates on the rising clock edge. Each edge does one of five things: it clears the register, holds it, shifts it toward the high end, shifts it toward the low end, or loads it from the parallel bus. The parallel bus serves two purposes. It carries load data into the block, and it carries the register contents back out through a three-state driver.

The bus is modelled as three signals. The input vector carries data into the block, the output vector carries data out, and a drive flag tells the surrounding logic whether the block owns the bus. The drive flag turns off when either active-low enable is high. It also turns off whenever the load mode is selected, so that an external source can put data on the bus during a load. The register keeps working while the bus is undriven.

The lowest and highest bits also appear on dedicated serial outputs that are always driven. Several blocks can therefore be chained to build a longer shift register.

Top module: `usr_shift_io`

## Requirements
- R1: When `clr_n` is low at a rising clock edge, every register bit becomes 0, whatever value `mode` has.
- R2: With `clr_n` high and `mode` = 2'b11 (load), each register bit takes the value of the matching `bus_in` bit at the clock edge.
- R3: With `clr_n` high and `mode` = 2'b01 (shift up), `ser_in_r` enters bit 0 and every bit i moves to bit i+1. The old top bit is lost.
- R4: With `clr_n` high and `mode` = 2'b10 (shift down), `ser_in_l` enters the top bit and every bit i moves to bit i-1. The old bit 0 is lost.
- R5: With `clr_n` high and `mode` = 2'b00 (hold), the register contents stay unchanged.
- R6: `bus_drive` is 0 while either `oe_a_n` or `oe_b_n` is 1. Clear, shift, load and hold still update the register in that state.
- R7: `bus_drive` is 0 whenever `mode` = 2'b11, even when both enables are low.
- R8: `bus_drive` is 1 when both enables are low and `mode` is not 2'b11. While `bus_drive` is 1, `bus_out` equals the register contents.
- R9: `ser_out_lo` always equals register bit 0 and `ser_out_hi` always equals the top register bit, whatever the enable inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on the rising edge |
| clr_n | input | 1 | Active-low synchronous clear; takes priority over `mode` |
| mode | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_r | input | 1 | Serial input that enters bit 0 during a shift up |
| ser_in_l | input | 1 | Serial input that enters the top bit during a shift down |
| oe_a_n | input | 1 | First active-low bus output enable |
| oe_b_n | input | 1 | Second active-low bus output enable |
| bus_in | input | WIDTH | Data sampled from the parallel bus during a load |
| bus_out | output | WIDTH | Register contents presented to the parallel bus |
| bus_drive | output | 1 | High when the block drives the parallel bus |
| ser_out_lo | output | 1 | Register bit 0 |
| ser_out_hi | output | 1 | Top register bit |

## Verification
The hardest condition to reach from the ports is the bus hand-over during a load. The register must sample `bus_in` in the same cycle in which its own driver has released the bus. Meanwhile the external source may drive the bus only while `bus_drive` is low. To reach this, the bench selects load mode and confirms that `bus_drive` has dropped. Only then does it place data on the bus, and it checks that the two drivers never overlap. Two instances are also chained through their serial pins. The bench then shifts the chained pair a full sixteen bits in each direction, which tests the end bits across the boundary between the two blocks.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHUP = 2'b01,
        MODE_SHDN = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

    typedef struct packed {
        logic      clr;
        usr_mode_e mode;
        logic      fill_lo;
        logic      fill_hi;
    } usr_ctl_t;

    function automatic usr_ctl_t usr_decode(input logic clr_n,
                                            input logic [1:0] mode,
                                            input logic sin_r,
                                            input logic sin_l);
        usr_ctl_t c;
        c.clr     = ~clr_n;
        c.mode    = usr_mode_e'(mode);
        c.fill_lo = sin_r;
        c.fill_hi = sin_l;
        return c;
    endfunction

    function automatic logic usr_bus_owned(input logic oe_a_n,
                                           input logic oe_b_n,
                                           input usr_mode_e m);
        return (~oe_a_n) & (~oe_b_n) & (m != MODE_LOAD);
    endfunction

endpackage

// File: rtl/usr_next_state.sv
module usr_next_state
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  usr_ctl_t           ctl,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   load_val,
    output logic [WIDTH-1:0]   nxt
);

    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_lo
            assign from_below = ctl.fill_lo;
        end else begin : g_lo_mid
            assign from_below = cur[i-1];
        end

        if (i == TOP) begin : g_hi
            assign from_above = ctl.fill_hi;
        end else begin : g_hi_mid
            assign from_above = cur[i+1];
        end

        always_comb begin
            if (ctl.clr) begin
                nxt[i] = 1'b0;
            end else begin
                unique case (ctl.mode)
                    MODE_HOLD: nxt[i] = cur[i];
                    MODE_SHUP: nxt[i] = from_below;
                    MODE_SHDN: nxt[i] = from_above;
                    MODE_LOAD: nxt[i] = load_val[i];
                    default:   nxt[i] = cur[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/usr_state_reg.sv
module usr_state_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        q <= d;
    end

endmodule

// File: rtl/usr_bus_drive.sv
module usr_bus_drive
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  usr_mode_e        mode,
    input  logic [WIDTH-1:0] state,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_drive
);

    logic owned;

    always_comb begin
        owned     = usr_bus_owned(oe_a_n, oe_b_n, mode);
        bus_drive = owned;
        bus_out   = owned ? state : '0;
    end

endmodule

// File: rtl/usr_shift_io.sv
module usr_shift_io
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_in_r,
    input  logic             ser_in_l,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_drive,
    output logic             ser_out_lo,
    output logic             ser_out_hi
);

    localparam int TOP = WIDTH - 1;

    usr_ctl_t         ctl;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    assign ctl = usr_decode(clr_n, mode, ser_in_r, ser_in_l);

    usr_next_state #(.WIDTH(WIDTH)) u_next (
        .ctl      (ctl),
        .cur      (state_q),
        .load_val (bus_in),
        .nxt      (state_d)
    );

    usr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .d   (state_d),
        .q   (state_q)
    );

    usr_bus_drive #(.WIDTH(WIDTH)) u_bus (
        .oe_a_n    (oe_a_n),
        .oe_b_n    (oe_b_n),
        .mode      (ctl.mode),
        .state     (state_q),
        .bus_out   (bus_out),
        .bus_drive (bus_drive)
    );

    assign ser_out_lo = state_q[0];
    assign ser_out_hi = state_q[TOP];

endmodule

// File: rtl/usr_shift_io_chk.sv
module usr_shift_io_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       mode,
    input logic             ser_in_r,
    input logic             ser_in_l,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_drive,
    input logic             ser_out_lo,
    input logic             ser_out_hi,
    input logic [WIDTH-1:0] state_q
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (!clr_n) armed <= 1'b1;
    end

    a_r1_clear: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> state_q == '0);

    a_r2_load: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && mode == 2'b11) |=> state_q == $past(bus_in));

    a_r3_shift_up: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && mode == 2'b01) |=>
            state_q == {$past(state_q[WIDTH-2:0]), $past(ser_in_r)});

    a_r4_shift_down: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && mode == 2'b10) |=>
            state_q == {$past(ser_in_l), $past(state_q[WIDTH-1:1])});

    a_r5_hold: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && mode == 2'b00) |=> $stable(state_q));

    a_r6_enable_off: assert property (@(posedge clk) disable iff (!armed)
        (oe_a_n || oe_b_n) |-> !bus_drive);

    a_r7_load_release: assert property (@(posedge clk) disable iff (!armed)
        (mode == 2'b11) |-> !bus_drive);

    a_r8_bus_value: assert property (@(posedge clk) disable iff (!armed)
        bus_drive |-> bus_out == state_q);

    a_r9_serial_ends: assert property (@(posedge clk) disable iff (!armed)
        (ser_out_lo == state_q[0]) && (ser_out_hi == state_q[WIDTH-1]));

endmodule

bind usr_shift_io usr_shift_io_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .clr_n      (clr_n),
    .mode       (mode),
    .ser_in_r   (ser_in_r),
    .ser_in_l   (ser_in_l),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .bus_in     (bus_in),
    .bus_out    (bus_out),
    .bus_drive  (bus_drive),
    .ser_out_lo (ser_out_lo),
    .ser_out_hi (ser_out_hi),
    .state_q    (state_q)
);

// File: tb/usr_shift_io_test.sv
module usr_shift_io_test;

    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         clr_n = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic         sin_r = 1'b0;
    logic         sin_l = 1'b0;
    logic         oe_a_n = 1'b0;
    logic         oe_b_n = 1'b0;
    logic [W-1:0] bus_a_in = '0;
    logic [W-1:0] bus_b_in = '0;
    logic         ext_drive = 1'b0;

    logic [W-1:0] bus_a_out, bus_b_out;
    logic         drv_a, drv_b;
    logic         lo_a, hi_a, lo_b, hi_b;

    // chained pair: uut holds the low byte, dn the high byte
    usr_shift_io #(.WIDTH(W)) uut (
        .clk(clk), .clr_n(clr_n), .mode(mode),
        .ser_in_r(sin_r), .ser_in_l(lo_b),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .bus_in(bus_a_in), .bus_out(bus_a_out), .bus_drive(drv_a),
        .ser_out_lo(lo_a), .ser_out_hi(hi_a)
    );

    usr_shift_io #(.WIDTH(W)) dn (
        .clk(clk), .clr_n(clr_n), .mode(mode),
        .ser_in_r(hi_a), .ser_in_l(sin_l),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .bus_in(bus_b_in), .bus_out(bus_b_out), .bus_drive(drv_b),
        .ser_out_lo(lo_b), .ser_out_hi(hi_b)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] exp_a, exp_b;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // clock one edge with current inputs, then park in hold with bus enabled and read back
    task automatic tick_and_read(input string tag);
        @(posedge clk);
        #2;
        mode = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0; ext_drive = 1'b0;
        #1;
        check({tag, " low drive"}, {31'd0, drv_a}, 32'd1);
        check({tag, " low value"}, {24'd0, bus_a_out}, {24'd0, exp_a});
        check({tag, " high value"}, {24'd0, bus_b_out}, {24'd0, exp_b});
    endtask

    task automatic t_reset();
        clr_n = 1'b0; mode = 2'b11; bus_a_in = 8'hFF; bus_b_in = 8'hFF;
        exp_a = '0; exp_b = '0;
        tick_and_read("R1 clear over load");
        clr_n = 1'b1;
        check("R9 reset serial ends", {30'd0, lo_a, hi_a}, 32'd0);
    endtask

    task automatic t_load(input logic [W-1:0] a, input logic [W-1:0] b);
        mode = 2'b11;
        #1;
        check("R7 released in load", {30'd0, drv_a, drv_b}, 32'd0);
        if (!drv_a && !drv_b) begin
            ext_drive = 1'b1;
            bus_a_in = a; bus_b_in = b;
        end
        check("R7 no contention", {31'd0, ext_drive & (drv_a | drv_b)}, 32'd0);
        exp_a = a; exp_b = b;
        tick_and_read("R2 load");
        check("R9 ends after load", {30'd0, lo_a, hi_b}, {30'd0, a[0], b[W-1]});
    endtask

    task automatic t_up(input logic [15:0] bits, input int n);
        for (int k = 0; k < n; k++) begin
            logic [15:0] v;
            mode = 2'b01; sin_r = bits[k];
            v = {exp_b, exp_a};
            v = {v[14:0], bits[k]};
            {exp_b, exp_a} = v;
            tick_and_read("R3 shift up");
        end
    endtask

    task automatic t_down(input logic [15:0] bits, input int n);
        for (int k = 0; k < n; k++) begin
            logic [15:0] v;
            mode = 2'b10; sin_l = bits[k];
            v = {exp_b, exp_a};
            v = {bits[k], v[15:1]};
            {exp_b, exp_a} = v;
            tick_and_read("R4 shift down");
        end
    endtask

    task automatic t_hold();
        mode = 2'b00; sin_r = 1'b1; sin_l = 1'b1; bus_a_in = ~exp_a;
        repeat (3) @(posedge clk);
        tick_and_read("R5 hold");
    endtask

    task automatic t_enables();
        oe_a_n = 1'b1; oe_b_n = 1'b0; mode = 2'b00;
        #1;
        check("R6 first enable off", {31'd0, drv_a}, 32'd0);
        check("R9 ends while disabled", {31'd0, lo_a}, {31'd0, exp_a[0]});
        oe_a_n = 1'b0; oe_b_n = 1'b1;
        #1;
        check("R6 second enable off", {31'd0, drv_a}, 32'd0);
        // register still shifts while bus released
        mode = 2'b01; sin_r = 1'b1;
        @(posedge clk);
        #2;
        check("R9 hi end undriven bus", {31'd0, hi_a}, {31'd0, exp_a[W-2]});
        {exp_b, exp_a} = {exp_b[W-2:0], exp_a[W-1], exp_a[W-2:0], 1'b1};
        mode = 2'b00; oe_b_n = 1'b0;
        #1;
        check("R6 shift while disabled", {24'd0, bus_a_out}, {24'd0, exp_a});
        check("R8 drive restored", {31'd0, drv_a}, 32'd1);
        // clear while disabled
        oe_a_n = 1'b1; clr_n = 1'b0;
        @(posedge clk);
        #2;
        clr_n = 1'b1;
        exp_a = '0; exp_b = '0;
        tick_and_read("R6 clear while disabled");
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #5;
        t_reset();
        t_load(8'hA5, 8'h3C);
        t_up(16'b1011_0010_1100_0111, 16);
        t_load(8'h81, 8'h7E);
        t_down(16'b0110_1001_0011_1010, 16);
        t_load(8'h5A, 8'hC3);
        t_up(16'h0003, 3);
        t_hold();
        t_enables();
        t_load(8'hFF, 8'h01);
        t_down(16'h0000, 9);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule